// File: doc/BRIEF.md
# Stop-Synchronized Output Selector

This block drives a parallel output port from one of three sources: a stored value A, a stored value B, or the live parallel input port. A bus slave in front of it supplies write strobes carrying one byte each, and a strobe that marks a bus STOP. The two upper bits of every written byte form a source-select field. Both stored values share this one field. The lower bits are the payload, and bit 6 of the byte picks which stored value the payload goes into.

Writes are held in a staging set and have no visible effect until the next STOP. A STOP that follows at least one write starts a modelled non-volatile commit. The commit lasts a fixed number of clock cycles, worked out from the clock rate and the commit time in milliseconds. While it runs, a busy flag is high. When it ends, the staged values become the active values in one cycle. Two external pins take priority over the stored select field. One is a mux-select pin. The other is an active-low override pin. Either one routes the live input port straight to the output without delay.

Top module: `stopsync_out_sel`

## Requirements
- R1: While reset is low and on the first cycle after it, both stored values and the select field are zero. With override_n high and mux_sel low, port_y is therefore zero and commit_busy is low, with no commit delay.
- R2: A byte on wr_byte loads wr_byte[7:6] into the one shared select field. It loads wr_byte[5:0] into value A when wr_byte[6] is 0 and into value B when wr_byte[6] is 1.
- R3: A write does not change port_y or commit_busy before a STOP arrives. A STOP with no write since the previous STOP leaves commit_busy low and port_y unchanged.
- R4: A STOP that follows a write raises commit_busy at the next clock edge. commit_busy stays high for exactly COMMIT_CYCLES = CLK_KHZ*COMMIT_MS cycles. The new values reach port_y at the same edge where commit_busy falls.
- R5: With override_n high, mux_sel low and the active select equal to 2'b10, port_y follows port_i combinationally.
- R6: The active select value 2'b11 behaves the same as 2'b10.
- R7: With override_n high and mux_sel low, the active select 2'b00 shows value A and 2'b01 shows value B.
- R8: With override_n high and mux_sel high, port_y follows port_i, whatever the select field holds.
- R9: With override_n low, port_y follows port_i, whatever mux_sel and the select field hold.
- R10: A STOP that follows a new write while a commit is running restarts the full count. At the end of that count the newest staged values become active, and the earlier values never reach the output on their own.
- R11: When a write and a STOP fall in the same cycle, that write is part of the commit the STOP starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe: wr_byte holds a written byte |
| wr_byte | input | DATA_W+2 | Written byte: [7:6] select, [6] also picks the destination, [5:0] payload |
| stop_stb | input | 1 | One-cycle strobe marking a bus STOP |
| port_i | input | DATA_W | Live parallel input port |
| mux_sel | input | 1 | High forces the input port onto the output |
| override_n | input | 1 | Low forces the input port onto the output |
| port_y | output | DATA_W | Selected output value |
| commit_busy | output | 1 | High while a non-volatile commit is running |

## Verification
Each fault in the internal state shows up at the ports in its own way. A staging register that leaks too early changes port_y before the STOP. A wrong commit count moves the falling edge of commit_busy and the switch of port_y away from exactly COMMIT_CYCLES edges after the STOP. If a restart is lost, the older value appears mid-window, COMMIT_CYCLES after the first STOP. A wrong priority among override_n, mux_sel and the select field shows as a wrong port_y in the same cycle the pins change, because that path has no register.

// File: rtl/sso_pkg.sv
// Package: shared types for the stop-synchronized output selector.
// Assumes a 2-bit select field; the upper bit alone picks the live port.
package sso_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_REG_A    = 2'b00,
        SRC_REG_B    = 2'b01,
        SRC_PORT     = 2'b10,
        SRC_PORT_ALT = 2'b11
    } sso_src_e;

    // True when the select code routes the live input port
    function automatic logic sso_is_port(input sso_src_e s);
        return (s == SRC_PORT) || (s == SRC_PORT_ALT);
    endfunction

endpackage

// File: rtl/sso_stage.sv
// Module: sso_stage
// Holds the values written since the last STOP and merges the write of the
// current cycle into them. It also raises start_commit when a STOP arrives
// with at least one write pending, including a write in the same cycle.
// Assumes wr_stb and stop_stb are single-cycle strobes from the bus slave.
module sso_stage
    import sso_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W+1:0] wr_byte,
    input  logic              stop_stb,
    output sso_src_e          nxt_sel,
    output logic [DATA_W-1:0] nxt_a,
    output logic [DATA_W-1:0] nxt_b,
    output logic              start_commit
);

    localparam int SEL_LO  = DATA_W;
    localparam int DEST_B  = DATA_W;

    sso_src_e          stg_sel;
    logic [DATA_W-1:0] stg_a;
    logic [DATA_W-1:0] stg_b;
    logic              dirty;

    // Merge the write of the current cycle over the staged values
    always_comb begin
        nxt_sel = stg_sel;
        nxt_a   = stg_a;
        nxt_b   = stg_b;
        if (wr_stb) begin
            nxt_sel = sso_src_e'(wr_byte[SEL_LO +: SEL_W]);
            if (wr_byte[DEST_B])
                nxt_b = wr_byte[DATA_W-1:0];
            else
                nxt_a = wr_byte[DATA_W-1:0];
        end
    end

    // A commit starts only on a STOP that has something to commit
    always_comb begin
        start_commit = stop_stb && (dirty || wr_stb);
    end

    // Keep the staged values and the pending-write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_sel <= SRC_REG_A;
            stg_a   <= '0;
            stg_b   <= '0;
            dirty   <= 1'b0;
        end else begin
            stg_sel <= nxt_sel;
            stg_a   <= nxt_a;
            stg_b   <= nxt_b;
            dirty   <= stop_stb ? 1'b0 : (dirty || wr_stb);
        end
    end

endmodule

// File: rtl/sso_commit.sv
// Module: sso_commit
// Models the non-volatile commit. On start it takes a snapshot of the staged
// values and counts COMMIT_CYCLES edges. At the last edge the snapshot
// becomes the active set. A new start while busy reloads both the snapshot
// and the count.
// Assumes COMMIT_CYCLES >= 1.
module sso_commit
    import sso_pkg::*;
#(
    parameter int DATA_W        = 6,
    parameter int COMMIT_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_commit,
    input  sso_src_e          nxt_sel,
    input  logic [DATA_W-1:0] nxt_a,
    input  logic [DATA_W-1:0] nxt_b,
    output sso_src_e          cur_sel,
    output logic [DATA_W-1:0] cur_a,
    output logic [DATA_W-1:0] cur_b,
    output logic              busy
);

    localparam int              CNT_W = $clog2(COMMIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(COMMIT_CYCLES - 1);

    logic [CNT_W-1:0]  cnt;
    sso_src_e          snap_sel;
    logic [DATA_W-1:0] snap_a;
    logic [DATA_W-1:0] snap_b;

    // Capture the snapshot and run the commit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            busy     <= 1'b0;
            snap_sel <= SRC_REG_A;
            snap_a   <= '0;
            snap_b   <= '0;
        end else if (start_commit) begin
            cnt      <= LOAD;
            busy     <= 1'b1;
            snap_sel <= nxt_sel;
            snap_a   <= nxt_a;
            snap_b   <= nxt_b;
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    // Move the snapshot into the active set when the count ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel <= SRC_REG_A;
            cur_a   <= '0;
            cur_b   <= '0;
        end else if (busy && !start_commit && cnt == '0) begin
            cur_sel <= snap_sel;
            cur_a   <= snap_a;
            cur_b   <= snap_b;
        end
    end

endmodule

// File: rtl/sso_mux.sv
// Module: sso_mux
// Output selection, purely combinational. The pins take priority over the
// stored select field, so the path from port_i to port_y has no register.
module sso_mux
    import sso_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  logic              override_n,
    input  logic              mux_sel,
    input  sso_src_e          cur_sel,
    input  logic [DATA_W-1:0] cur_a,
    input  logic [DATA_W-1:0] cur_b,
    input  logic [DATA_W-1:0] port_i,
    output logic [DATA_W-1:0] port_y
);

    // Pick the output source by priority: override, mux pin, then select
    always_comb begin
        if (!override_n || mux_sel || sso_is_port(cur_sel))
            port_y = port_i;
        else if (cur_sel == SRC_REG_B)
            port_y = cur_b;
        else
            port_y = cur_a;
    end

endmodule

// File: rtl/stopsync_out_sel.sv
// Module: stopsync_out_sel (top)
// Stop-synchronized output selector. Writes are staged, a STOP starts a
// modelled non-volatile commit of COMMIT_CYCLES = CLK_KHZ*COMMIT_MS cycles,
// and the output mux picks A, B or the live port.
// Assumes a synchronous active-low reset and single-cycle strobes.
module stopsync_out_sel
    import sso_pkg::*;
#(
    parameter int DATA_W    = 6,
    parameter int CLK_KHZ   = 100000,
    parameter int COMMIT_MS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W+1:0] wr_byte,
    input  logic              stop_stb,
    input  logic [DATA_W-1:0] port_i,
    input  logic              mux_sel,
    input  logic              override_n,
    output logic [DATA_W-1:0] port_y,
    output logic              commit_busy
);

    localparam int COMMIT_CYCLES = CLK_KHZ * COMMIT_MS;

    sso_src_e          nxt_sel;
    logic [DATA_W-1:0] nxt_a;
    logic [DATA_W-1:0] nxt_b;
    logic              start_commit;
    sso_src_e          cur_sel;
    logic [DATA_W-1:0] cur_a;
    logic [DATA_W-1:0] cur_b;

    sso_stage #(.DATA_W(DATA_W)) u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .wr_byte      (wr_byte),
        .stop_stb     (stop_stb),
        .nxt_sel      (nxt_sel),
        .nxt_a        (nxt_a),
        .nxt_b        (nxt_b),
        .start_commit (start_commit)
    );

    sso_commit #(.DATA_W(DATA_W), .COMMIT_CYCLES(COMMIT_CYCLES)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_commit (start_commit),
        .nxt_sel      (nxt_sel),
        .nxt_a        (nxt_a),
        .nxt_b        (nxt_b),
        .cur_sel      (cur_sel),
        .cur_a        (cur_a),
        .cur_b        (cur_b),
        .busy         (commit_busy)
    );

    sso_mux #(.DATA_W(DATA_W)) u_mux (
        .override_n (override_n),
        .mux_sel    (mux_sel),
        .cur_sel    (cur_sel),
        .cur_a      (cur_a),
        .cur_b      (cur_b),
        .port_i     (port_i),
        .port_y     (port_y)
    );

endmodule

// File: rtl/stopsync_out_sel_chk.sv
// Module: stopsync_out_sel_chk
// Assertion checker bound to stopsync_out_sel. It measures the length of
// each busy window with its own counter instead of a long $past.
module stopsync_out_sel_chk #(
    parameter int DATA_W = 6,
    parameter int NCYC   = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_stb,
    input logic              start_commit,
    input logic              override_n,
    input logic              mux_sel,
    input logic [1:0]        cur_sel,
    input logic [DATA_W-1:0] cur_a,
    input logic [DATA_W-1:0] cur_b,
    input logic [DATA_W-1:0] port_i,
    input logic [DATA_W-1:0] port_y,
    input logic              busy
);

    int run;

    // Count busy cycles since the most recent commit start
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 0;
        else if (start_commit)
            run <= 0;
        else if (busy)
            run <= run + 1;
        else
            run <= 0;
    end

    // R4: busy window is exactly NCYC cycles long
    a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run == NCYC);

    // R3: busy rises only after a STOP
    a_r3_busy_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_stb));

    // R4: active values change only as busy falls
    a_r4_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(cur_a) && $stable(cur_b) && $stable(cur_sel)) |-> $fell(busy));

    // R9: override low routes the live port
    a_r9_override: assert property (@(posedge clk) disable iff (!rst_n)
        !override_n |-> port_y == port_i);

    // R8: mux pin high routes the live port
    a_r8_mux_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (override_n && mux_sel) |-> port_y == port_i);

    // R7: select 00 shows A, 01 shows B
    a_r7_reg_a: assert property (@(posedge clk) disable iff (!rst_n)
        (override_n && !mux_sel && cur_sel == 2'b00) |-> port_y == cur_a);
    a_r7_reg_b: assert property (@(posedge clk) disable iff (!rst_n)
        (override_n && !mux_sel && cur_sel == 2'b01) |-> port_y == cur_b);

endmodule

bind stopsync_out_sel stopsync_out_sel_chk #(
    .DATA_W (DATA_W),
    .NCYC   (COMMIT_CYCLES)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_stb     (stop_stb),
    .start_commit (start_commit),
    .override_n   (override_n),
    .mux_sel      (mux_sel),
    .cur_sel      (cur_sel),
    .cur_a        (cur_a),
    .cur_b        (cur_b),
    .port_i       (port_i),
    .port_y       (port_y),
    .busy         (commit_busy)
);

// File: tb/test_stopsync_out_sel.sv
// Scoreboard bench: the driver pushes the expected port_y/commit_busy for
// the coming edge; the monitor pops and compares 2 ns after that edge.
module test_stopsync_out_sel;

    localparam int DW   = 6;
    localparam int KHZ  = 4;
    localparam int MS   = 2;
    localparam int NCYC = KHZ * MS;

    typedef struct {
        logic [DW-1:0] y;
        logic          busy;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_stb;
    logic [DW+1:0] wr_byte;
    logic          stop_stb;
    logic [DW-1:0] port_i;
    logic          mux_sel;
    logic          override_n;
    logic [DW-1:0] port_y;
    logic          commit_busy;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    stopsync_out_sel #(.DATA_W(DW), .CLK_KHZ(KHZ), .COMMIT_MS(MS)) i_stopsync_out_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_byte     (wr_byte),
        .stop_stb    (stop_stb),
        .port_i      (port_i),
        .mux_sel     (mux_sel),
        .override_n  (override_n),
        .port_y      (port_y),
        .commit_busy (commit_busy)
    );

    // Monitor: compare after each edge against the queued expectation
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (port_y !== e.y || commit_busy !== e.busy) begin
                n_fail++;
                $display("FAIL %s: port_y=%h busy=%b expected port_y=%h busy=%b",
                         e.tag, port_y, commit_busy, e.y, e.busy);
            end
        end
    end

    // Driver: queue expectation for the next edge, then move to next negedge
    task automatic tick(input logic [DW-1:0] y, input logic b, input string tag);
        exp_t e;
        e.y = y; e.busy = b; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        wr_stb   = 1'b0;
        stop_stb = 1'b0;
    endtask

    // Remaining busy cycles after the start edge, then the switch edge
    task automatic wait_commit(input logic [DW-1:0] y_old, input logic [DW-1:0] y_new,
                               input string tag);
        for (int k = 1; k < NCYC; k++) tick(y_old, 1'b1, tag);
        tick(y_new, 1'b0, tag);
    endtask

    task automatic wr(input logic [DW+1:0] v);
        wr_stb  = 1'b1;
        wr_byte = v;
    endtask

    initial begin
        rst_n = 1'b0; wr_stb = 1'b0; wr_byte = '0; stop_stb = 1'b0;
        port_i = 6'h2A; mux_sel = 1'b0; override_n = 1'b1;
        @(negedge clk);
        tick(6'h00, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        tick(6'h00, 1'b0, "R1 after reset");

        // R3: write without STOP has no effect
        wr(8'h15);
        tick(6'h00, 1'b0, "R3 write held");
        tick(6'h00, 1'b0, "R3 write held");
        tick(6'h00, 1'b0, "R3 write held");
        // R4: STOP starts the commit, value appears when busy falls
        stop_stb = 1'b1;
        tick(6'h00, 1'b1, "R4 start");
        wait_commit(6'h00, 6'h15, "R4 commit A");

        // R2/R7: bit6 set routes payload to B and selects B
        wr(8'h4C);
        tick(6'h15, 1'b0, "R2 staged");
        stop_stb = 1'b1;
        tick(6'h15, 1'b1, "R2 start");
        wait_commit(6'h15, 6'h0C, "R7 shows B");

        // R3: STOP with nothing pending
        stop_stb = 1'b1;
        tick(6'h0C, 1'b0, "R3 empty stop");
        tick(6'h0C, 1'b0, "R3 empty stop");

        // R11 + R5: write and STOP together, select 10
        wr(8'hB3);
        stop_stb = 1'b1;
        tick(6'h0C, 1'b1, "R11 same-cycle");
        wait_commit(6'h0C, 6'h2A, "R5 port via select");
        port_i = 6'h11;
        tick(6'h11, 1'b0, "R5 live follow");

        // R6: select 11
        wr(8'hC7);
        stop_stb = 1'b1;
        tick(6'h11, 1'b1, "R6 start");
        wait_commit(6'h11, 6'h11, "R6 commit");
        port_i = 6'h3C;
        tick(6'h3C, 1'b0, "R6 live follow");

        // R10: restart during commit
        wr(8'h01);
        stop_stb = 1'b1;
        tick(6'h3C, 1'b1, "R10 first start");
        tick(6'h3C, 1'b1, "R10 busy");
        tick(6'h3C, 1'b1, "R10 busy");
        tick(6'h3C, 1'b1, "R10 busy");
        wr(8'h45);
        stop_stb = 1'b1;
        tick(6'h3C, 1'b1, "R10 restart");
        wait_commit(6'h3C, 6'h05, "R10 newest value");

        // R8: mux pin
        mux_sel = 1'b1;
        tick(6'h3C, 1'b0, "R8 mux pin");
        port_i = 6'h22;
        tick(6'h22, 1'b0, "R8 mux pin live");
        mux_sel = 1'b0;
        tick(6'h05, 1'b0, "R7 back to B");

        // R9: override
        override_n = 1'b0;
        tick(6'h22, 1'b0, "R9 override");
        port_i = 6'h02;
        tick(6'h02, 1'b0, "R9 override live");
        override_n = 1'b1;
        tick(6'h05, 1'b0, "R9 release");

        @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule